// File: doc/BRIEF.md
# Write-Only Two-Wire Converter Register Slave

This block is a receive-only slave on a two-wire serial bus. It loads an array of eight 8-bit converter output registers. A fast system clock oversamples the bus clock and data lines. Each line passes through a two-flop synchronizer. Edge logic then finds START and STOP conditions and the bus clock edges.

A transfer opens with an address byte. The upper four address bits are fixed, and the lower three come from select pins. After the address come command and output byte pairs. The command byte names a channel, and the output byte that follows is loaded into that channel's register. A transfer may end on a lone command byte.

The block never returns data to the master. Its only drive onto the bus is an open-drain pull-low enable, used to acknowledge accepted bytes. The register outputs are plain levels that downstream logic reads at any time. There is no handshake on them, and they hold their value until the next write to the same channel. The system clock must run at least 16 times the bus clock rate, so a 400 kHz bus needs at least 6.4 MHz.

Top module: `dac_bus_slave`

## Requirements
- R1: After reset, all eight channel registers read 0x00 and the pull-low enable is inactive.
- R2: After a START, an address byte equal to {0101, addr_sel[2:0], 0} is acknowledged. The slave asserts the pull-low enable during the ninth bus clock.
- R3: An address byte with different upper seven bits, or with bit 0 set to 1 (a read), is not acknowledged. The bytes that follow, up to the next START, are neither acknowledged nor applied.
- R4: Bytes are received most significant bit first. A command byte is acknowledged, and its bits [2:0] select the channel while the upper five bits are ignored. The output byte that follows is acknowledged and written to that channel once the falling bus clock edge ends its ninth clock.
- R5: The pull-low enable is asserted only while the bus clock is low after the eighth bit of an accepted byte. It is released after the falling edge that ends the ninth clock.
- R6: One transfer may carry several command and output pairs, and each pair updates its own channel.
- R7: A command byte followed directly by STOP is acknowledged and changes no register.
- R8: A STOP in the middle of a byte discards the partial byte and returns the slave to idle. Bytes clocked after it without a new START are neither acknowledged nor applied.
- R9: A repeated START in the middle of a byte discards the partial byte and restarts address matching, so a new address and its pairs are then accepted.
- R10: At most one channel register changes in any system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired value) |
| addr_sel | input | 3 | Low three bits of the slave address |
| sda_pull | output | 1 | Open-drain enable; 1 pulls the data line low |
| dac_level | output | 8x8 | Channel register values, channel n in bits [8n+7:8n] |

## Verification
An acknowledge appears about three system clocks after the falling bus clock edge that ends the eighth bit. That delay comes from two synchronizer flops and the pull register. The bench therefore samples the pull-low enable a quarter bus period into the high phase of the ninth clock, and again a quarter period after that clock's falling edge to confirm release. A register update arrives about three system clocks after the falling edge that ends the ninth clock of an output byte. A monitor compares every register change, on the falling system clock edge where it appears, against the head of a queue of expected writes. After each scenario the bench compares the whole array with its model, so that ignored bytes and dropped pairs show up as differences at the outputs.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int SEL_W = 3;
  localparam logic [3:0] ADDR_HI = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } dbs_state_t;
endpackage

// File: rtl/dbs_sync.sv
module dbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES:0] scl_q;
  logic [STAGES:0] sda_q;
  logic scl_prev;
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_in};
      sda_q <= {sda_q[STAGES-1:0], sda_in};
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_prev = scl_q[STAGES];
  assign sda_prev = sda_q[STAGES];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_evt = scl_s & scl_prev & ~sda_s & sda_prev;
  assign stop_evt  = scl_s & scl_prev & sda_s & ~sda_prev;
endmodule

// File: rtl/dbs_frame.sv
module dbs_frame
  import dbs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [SEL_W-1:0] addr_sel,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [CH_W-1:0]  wr_chan,
  output logic [DW-1:0]    wr_data
);
  localparam logic [3:0] LAST_BIT = 4'(DW);
  localparam logic [3:0] ACK_BIT  = 4'(DW + 1);

  dbs_state_t      state;
  logic [3:0]      cnt;
  logic [DW-1:0]   shreg;
  logic [CH_W-1:0] chan_q;
  logic [DW-1:0]   data_q;
  logic            active;
  logic            addr_ok;

  assign active  = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_DATA);
  assign addr_ok = (shreg[7:1] == {ADDR_HI, addr_sel}) && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      chan_q   <= '0;
      data_q   <= '0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (active && scl_rise) begin
      if (cnt < LAST_BIT) shreg <= {shreg[DW-2:0], sda_s};
      if (cnt != ACK_BIT) cnt <= cnt + 4'd1;
    end else if (active && scl_fall) begin
      if (cnt == LAST_BIT) begin
        case (state)
          ST_ADDR: begin
            if (addr_ok) sda_pull <= 1'b1;
            else state <= ST_SKIP;
          end
          ST_CMD: begin
            sda_pull <= 1'b1;
            chan_q   <= shreg[CH_W-1:0];
          end
          ST_DATA: begin
            sda_pull <= 1'b1;
            data_q   <= shreg;
          end
          default: ;
        endcase
      end else if (cnt == ACK_BIT) begin
        sda_pull <= 1'b0;
        cnt      <= '0;
        case (state)
          ST_ADDR: state <= ST_CMD;
          ST_CMD:  state <= ST_DATA;
          ST_DATA: state <= ST_CMD;
          default: ;
        endcase
      end
    end
  end

  assign wr_en   = scl_fall && (cnt == ACK_BIT) && (state == ST_DATA)
                   && !start_evt && !stop_evt;
  assign wr_chan = chan_q;
  assign wr_data = data_q;
endmodule

// File: rtl/dbs_regs.sv
module dbs_regs #(
  parameter int NCH  = 8,
  parameter int DW   = 8,
  parameter int CH_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_chan,
  input  logic [DW-1:0]           wr_data,
  output logic [NCH-1:0][DW-1:0]  level
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level[g] <= '0;
      else if (wr_en && (wr_chan == CH_W'(g))) level[g] <= wr_data;
    end
  end
endmodule

// File: rtl/dac_bus_slave.sv
module dac_bus_slave
  import dbs_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  input  logic [SEL_W-1:0]       addr_sel,
  output logic                   sda_pull,
  output logic [NCH-1:0][DW-1:0] dac_level
);
  localparam int CH_W = $clog2(NCH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic            wr_en;
  logic [CH_W-1:0] wr_chan;
  logic [DW-1:0]   wr_data;

  dbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  dbs_frame #(.DW(DW), .CH_W(CH_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .wr_en(wr_en),
    .wr_chan(wr_chan), .wr_data(wr_data)
  );

  dbs_regs #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_data(wr_data), .level(dac_level)
  );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   scl_fall,
  input logic                   start_evt,
  input logic                   stop_evt,
  input logic                   sda_pull,
  input logic [NCH-1:0][DW-1:0] dac_level
);
  logic [NCH-1:0][DW-1:0] prev_level;
  logic [NCH-1:0]         chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_level <= '0;
    else        prev_level <= dac_level;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chg
    assign chg[g] = dac_level[g] != prev_level[g];
  end

  // R5: acknowledge drive begins only while the bus clock is low
  a_r5_pull_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  // R8: a STOP frees the data line
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  // R9: a START frees the data line
  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

  // R10: one channel at most changes per cycle
  a_r10_single_update: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  // R4: a register changes only right after a falling bus clock edge
  a_r4_update_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> $past(scl_fall));
endmodule

bind dac_bus_slave dbs_checker #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt), .sda_pull(sda_pull),
  .dac_level(dac_level)
);

// File: tb/dac_bus_slave_test.sv
`timescale 1ns/1ps
module dac_bus_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic [2:0] addr_sel = 3'd5;
  logic sda_pull;
  logic [7:0][7:0] dac_level;
  logic sda_bus;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  logic [7:0] model [8];
  logic [7:0] prev [8];
  int         exp_ch [$];
  logic [7:0] exp_val [$];

  always #5 clk = ~clk;

  assign sda_bus = msda & ~sda_pull;

  dac_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .dac_level(dac_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wq(Q);
    scl = 1'b1;  wq(Q);
    msda = 1'b0; wq(Q);
    scl = 1'b0;  wq(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wq(Q);
    scl = 1'b1;  wq(Q);
    msda = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    msda = b;   wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ack_exp, input string req);
    send_bits(v, 8);
    msda = 1'b1; wq(Q);
    scl = 1'b1;  wq(Q);
    chk({req, " ack"}, {31'd0, sda_pull}, {31'd0, ack_exp});
    wq(Q);
    scl = 1'b0;  wq(Q);
    chk("R5 release", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic wr_pair(input logic [7:0] cmd, input logic [7:0] v, input string req);
    send_byte(cmd, 1'b1, req);
    exp_ch.push_back(int'(cmd[2:0]));
    exp_val.push_back(v);
    model[cmd[2:0]] = v;
    send_byte(v, 1'b1, req);
  endtask

  task automatic cmp_all(input string req);
    wq(2*Q);
    for (int c = 0; c < 8; c++) chk(req, {24'd0, dac_level[c]}, {24'd0, model[c]});
    chk({req, " pending"}, exp_ch.size(), 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 8; c++) begin
        if (dac_level[c] !== prev[c]) begin
          nvec++;
          if (exp_ch.size() == 0) begin
            nfail++;
            $display("FAIL R4 unexpected write ch%0d actual=%0h expected=none", c, dac_level[c]);
          end else begin
            int ec;
            logic [7:0] ev;
            ec = exp_ch.pop_front();
            ev = exp_val.pop_front();
            if (ec != c || dac_level[c] !== ev) begin
              nfail++;
              $display("FAIL R4 write actual=ch%0d:%0h expected=ch%0d:%0h", c, dac_level[c], ec, ev);
            end
          end
          prev[c] = dac_level[c];
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) begin model[c] = 8'h00; prev[c] = 8'h00; end
    wq(4);
    chk("R1 pull", {31'd0, sda_pull}, 32'd0);
    chk("R1 regs", dac_level[31:0], 32'd0);
    chk("R1 regs hi", dac_level[63:32], 32'd0);
    rst_n = 1'b1;
    wq(4);

    // R2 / R4: simple write, address 0x5A for addr_sel=5
    bus_start();
    send_byte(8'h5A, 1'b1, "R2");
    wr_pair(8'h03, 8'hA5, "R4");
    bus_stop();
    cmp_all("R4");

    // R6: several pairs, upper command bits ignored (0xF9 -> ch1)
    bus_start();
    send_byte(8'h5A, 1'b1, "R2");
    wr_pair(8'h00, 8'h12, "R6");
    wr_pair(8'h07, 8'hFF, "R6");
    wr_pair(8'hF9, 8'h81, "R6");
    wr_pair(8'h03, 8'h3C, "R6");
    bus_stop();
    cmp_all("R6");

    // R3: wrong address
    bus_start();
    send_byte(8'h58, 1'b0, "R3");
    send_byte(8'h02, 1'b0, "R3");
    send_byte(8'h77, 1'b0, "R3");
    bus_stop();
    cmp_all("R3");

    // R3: read request
    bus_start();
    send_byte(8'h5B, 1'b0, "R3");
    send_byte(8'h04, 1'b0, "R3");
    send_byte(8'h99, 1'b0, "R3");
    bus_stop();
    cmp_all("R3 read");

    // R7: lone trailing command
    bus_start();
    send_byte(8'h5A, 1'b1, "R2");
    wr_pair(8'h05, 8'h5E, "R7");
    send_byte(8'h06, 1'b1, "R7");
    bus_stop();
    cmp_all("R7");

    // R8: STOP inside a data byte, then bytes without START
    bus_start();
    send_byte(8'h5A, 1'b1, "R2");
    send_byte(8'h02, 1'b1, "R8");
    send_bits(8'hC3, 4);
    bus_stop();
    scl = 1'b0; wq(Q);
    send_byte(8'h5A, 1'b0, "R8");
    send_byte(8'h02, 1'b0, "R8");
    send_byte(8'h44, 1'b0, "R8");
    scl = 1'b1; wq(Q);
    bus_stop();
    cmp_all("R8");

    // R9: repeated START inside a data byte
    bus_start();
    send_byte(8'h5A, 1'b1, "R2");
    send_byte(8'h04, 1'b1, "R9");
    send_bits(8'hE7, 4);
    bus_start();
    send_byte(8'h5A, 1'b1, "R9");
    wr_pair(8'h04, 8'h6B, "R9");
    bus_stop();
    cmp_all("R9");

    // R2 / R3: address pins changed to 2 (0x54)
    addr_sel = 3'd2;
    wq(4);
    bus_start();
    send_byte(8'h5A, 1'b0, "R3");
    bus_stop();
    bus_start();
    send_byte(8'h54, 1'b1, "R2");
    wr_pair(8'h06, 8'h0F, "R2");
    bus_stop();
    cmp_all("R2");

    done = 1;
    summary();
    $finish;
  end
endmodule